// File: doc/BRIEF.md
# Byte-Wide Many-Time-Programmable Flash Emulator

This block models a small byte-wide flash array that sits behind an EPROM-style parallel interface. All operations are qualified by an active-low chip enable. Reads are gated by an active-low output enable. Programming and chip erase are not started by command writes. They are selected by two digital flags that stand in for high-voltage levels: one for the programming supply and one for address line 9. A falling edge on an active-low strobe then launches the operation.

A program operation can only clear bits. The stored byte becomes the old byte ANDed with the written byte. Only a chip erase can set bits, and it returns every location to FFh. Pulse durations are counted in clock cycles and set by parameters. A busy flag covers each pulse. An identification mode returns a fixed manufacturer byte and a fixed device byte, chosen by address bit 0.

Top module: `flash_emu`

## Requirements
- R1: `data_oe_o` is 1 exactly when `ce_ni` and `oe_ni` are both 0. Whenever `data_oe_o` is 0, `data_valid_o` is 0 and `data_o` is 00h.
- R2: While `ce_ni` is 1, a strobe edge starts no operation and the array contents stay unchanged, whatever the flags are.
- R3: With `ce_ni`=0, `oe_ni`=1, `vpp_hv_i`=1 and `a9_hv_i`=0, a strobe falling edge programs `data_i` at `addr_i`. With `oe_ni`=0 and `vpp_hv_i`=1, no operation starts.
- R4: Programming stores the old byte ANDed with `data_i`, so a program never sets a bit.
- R5: With `ce_ni`=0, `oe_ni`=1, `vpp_hv_i`=1 and `a9_hv_i`=1, a strobe falling edge erases the whole array to FFh. `addr_i` and `data_i` are ignored.
- R6: A falling edge is a clock edge at which `pgm_ni` is sampled 0 after it was sampled 1 at the previous edge. `busy_o` rises at that same edge.
- R7: With `ce_ni`=0, `oe_ni`=0, `a9_hv_i`=1 and `vpp_hv_i`=0, `data_o` is BFh when `addr_i[0]`=0 and A5h when `addr_i[0]`=1. Higher address bits are ignored and `data_valid_o` is 1.
- R8: `busy_o` stays high for exactly PROG_CYC cycles for a program and ERASE_CYC cycles for an erase. The array is updated at the edge where `busy_o` falls.
- R9: While `busy_o` is 1, `data_valid_o` is 0, `data_o` is 00h, and further strobe edges are ignored.
- R10: After reset every byte reads FFh and `busy_o` is 0.
- R11: With `ce_ni`=0, `oe_ni`=0 and both flags 0, `data_o` equals the stored byte at `addr_i` in the same cycle, and `data_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| pgm_ni | input | 1 | Program/erase strobe, active low |
| vpp_hv_i | input | 1 | Programming-supply high-voltage flag |
| a9_hv_i | input | 1 | Address-line-9 high-voltage flag |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data (00h when not valid) |
| data_oe_o | output | 1 | Bus drive qualifier |
| data_valid_o | output | 1 | Read data valid |
| busy_o | output | 1 | Program or erase pulse in progress |

## Verification
Read, identification and bus-qualifier results are combinational. The bench therefore samples them a few nanoseconds after it changes the inputs at a falling clock edge, inside the same cycle. A strobe driven low at a falling edge is seen at the next rising edge, and `busy_o` must already be high at the falling edge that follows. The bench then counts falling edges until `busy_o` drops and compares that count with PROG_CYC or ERASE_CYC. Array contents are read back only after `busy_o` has fallen, which is the cycle in which the commit becomes visible.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;
  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_READ,
    MODE_ID,
    MODE_PROG,
    MODE_ERASE,
    MODE_INHIBIT
  } flash_mode_e;
endpackage

// File: rtl/flash_mode_dec.sv
module flash_mode_dec
  import flash_emu_pkg::*;
(
  input  logic        ce_ni,
  input  logic        oe_ni,
  input  logic        vpp_hv_i,
  input  logic        a9_hv_i,
  output flash_mode_e mode_o
);
  always_comb begin
    if (ce_ni)                            mode_o = MODE_STANDBY;
    else if (vpp_hv_i && oe_ni && a9_hv_i) mode_o = MODE_ERASE;
    else if (vpp_hv_i && oe_ni)           mode_o = MODE_PROG;
    else if (vpp_hv_i)                    mode_o = MODE_INHIBIT;
    else if (!oe_ni && a9_hv_i)           mode_o = MODE_ID;
    else if (!oe_ni)                      mode_o = MODE_READ;
    else                                  mode_o = MODE_INHIBIT;
  end
endmodule

// File: rtl/flash_pulse_ctrl.sv
module flash_pulse_ctrl
  import flash_emu_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 100,
  localparam int MAX_CYC  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int CNT_W    = $clog2(MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_ni,
  input  flash_mode_e       mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              busy_o,
  output logic              prog_en_o,
  output logic              erase_en_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [7:0]        wdata_o
);
  logic             pgm_q;
  logic             is_erase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             fall;
  logic             start;
  logic             done;

  assign fall  = pgm_q && !pgm_ni;
  assign start = fall && !busy_o && (mode_i == MODE_PROG || mode_i == MODE_ERASE);
  assign done  = busy_o && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pgm_q      <= 1'b1;
      busy_o     <= 1'b0;
      is_erase_q <= 1'b0;
      cnt_q      <= '0;
      waddr_o    <= '0;
      wdata_o    <= 8'hFF;
    end else begin
      pgm_q <= pgm_ni;
      if (start) begin
        busy_o     <= 1'b1;
        is_erase_q <= (mode_i == MODE_ERASE);
        cnt_q      <= (mode_i == MODE_ERASE) ? CNT_W'(ERASE_CYC - 1) : CNT_W'(PROG_CYC - 1);
        waddr_o    <= addr_i;
        wdata_o    <= data_i;
      end else if (done) begin
        busy_o <= 1'b0;
      end else if (busy_o) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign prog_en_o  = done && !is_erase_q;
  assign erase_en_o = done && is_erase_q;

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cnt_q != '0) |=> busy_o); // R8
  AST_START_NEEDS_MODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(mode_i) == MODE_PROG || $past(mode_i) == MODE_ERASE)); // R3
  AST_STANDBY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_STANDBY && !busy_o) |=> !busy_o); // R2
endmodule

// File: rtl/flash_array.sv
module flash_array #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prog_en_i,
  input  logic              erase_en_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [7:0]        rdata_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (erase_en_i) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else if (prog_en_i) begin
      mem[waddr_i] <= mem[waddr_i] & wdata_i; // program clears bits only
    end
  end

  assign rdata_o = mem[raddr_i];

  AST_PROG_CLEARS_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_en_i |=> ((mem[$past(waddr_i)] & ~$past(mem[waddr_i])) == 8'h00)); // R4
  AST_ERASE_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_en_i |=> (mem[0] == 8'hFF && mem[DEPTH-1] == 8'hFF)); // R5
endmodule

// File: rtl/flash_emu.sv
module flash_emu
  import flash_emu_pkg::*;
#(
  parameter int   DEPTH     = 256,
  parameter int   PROG_CYC  = 20,
  parameter int   ERASE_CYC = 100,
  parameter logic [7:0] MFR_ID = 8'hBF,
  parameter logic [7:0] DEV_ID = 8'hA5,
  localparam int  ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              pgm_ni,
  input  logic              vpp_hv_i,
  input  logic              a9_hv_i,
  input  logic [7:0]        data_i,
  output logic [7:0]        data_o,
  output logic              data_oe_o,
  output logic              data_valid_o,
  output logic              busy_o
);
  flash_mode_e       mode;
  logic              prog_en;
  logic              erase_en;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wdata;
  logic [7:0]        rdata;

  flash_mode_dec i_dec (
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .vpp_hv_i (vpp_hv_i),
    .a9_hv_i  (a9_hv_i),
    .mode_o   (mode)
  );

  flash_pulse_ctrl #(
    .ADDR_W    (ADDR_W),
    .PROG_CYC  (PROG_CYC),
    .ERASE_CYC (ERASE_CYC)
  ) i_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pgm_ni     (pgm_ni),
    .mode_i     (mode),
    .addr_i     (addr_i),
    .data_i     (data_i),
    .busy_o     (busy_o),
    .prog_en_o  (prog_en),
    .erase_en_o (erase_en),
    .waddr_o    (waddr),
    .wdata_o    (wdata)
  );

  flash_array #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W)
  ) i_array (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .prog_en_i  (prog_en),
    .erase_en_i (erase_en),
    .waddr_i    (waddr),
    .wdata_i    (wdata),
    .raddr_i    (addr_i),
    .rdata_o    (rdata)
  );

  assign data_oe_o = !ce_ni && !oe_ni;

  always_comb begin
    data_valid_o = 1'b0;
    data_o       = 8'h00;
    if (data_oe_o && !busy_o) begin
      if (mode == MODE_READ) begin
        data_valid_o = 1'b1;
        data_o       = rdata;
      end else if (mode == MODE_ID) begin
        data_valid_o = 1'b1;
        data_o       = addr_i[0] ? DEV_ID : MFR_ID;
      end
    end
  end

  AST_NO_VALID_UNDRIVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni) |-> (!data_valid_o && data_o == 8'h00)); // R1
  AST_BUSY_BLOCKS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !data_valid_o); // R9
endmodule

// File: tb/test_flash_emu.sv
module test_flash_emu;
  localparam int DEPTH = 256;
  localparam int AW    = 8;
  localparam int PCYC  = 20;
  localparam int ECYC  = 100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1, oe_n = 1'b1, pgm_n = 1'b1, vpp = 1'b0, a9 = 1'b0;
  logic [7:0]    din = 8'h00;
  logic [7:0]    dout;
  logic          doe, dvalid, busy;

  int n_vec = 0;
  int n_err = 0;
  logic [7:0] model [DEPTH];

  always #10 clk = ~clk;

  flash_emu #(.DEPTH(DEPTH), .PROG_CYC(PCYC), .ERASE_CYC(ECYC)) i_flash_emu (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .ce_ni(ce_n), .oe_ni(oe_n),
    .pgm_ni(pgm_n), .vpp_hv_i(vpp), .a9_hv_i(a9), .data_i(din),
    .data_o(dout), .data_oe_o(doe), .data_valid_o(dvalid), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    ce_n = 0; oe_n = 0; vpp = 0; a9 = 0; addr = a;
    #3;
    chk(req, {dvalid, doe, dout}, {1'b1, 1'b1, exp});
  endtask

  // strobe low at a negedge; count cycles busy stays high
  task automatic pulse(input string req, input int exp_cyc, input bit poke);
    int cnt = 0;
    @(negedge clk);
    pgm_n = 0;
    @(negedge clk);
    chk({req, " R6 busy rise"}, busy, (exp_cyc > 0));
    while (busy && cnt < 1000) begin
      cnt++;
      if (poke) begin
        chk("R9 valid low while busy", {dvalid, dout}, 9'h000);
        pgm_n = ~pgm_n;
      end
      @(negedge clk);
    end
    pgm_n = 1;
    chk({req, " R8 busy length"}, cnt, exp_cyc);
    @(negedge clk);
  endtask

  task automatic prog(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 0; oe_n = 1; vpp = 1; a9 = 0; addr = a; din = d;
    pulse("R3 program", PCYC, 1'b0);
    model[a] = model[a] & d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;
    repeat (3) @(negedge clk);
    chk("R10 busy after reset", busy, 0);
    rst_n = 1;
    // R10: all bytes erased after reset
    for (int i = 0; i < DEPTH; i++) do_read(AW'(i), "R10 reset content", 8'hFF);
    // R1: bus qualifier for every ce/oe combination
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      ce_n = k[0]; oe_n = k[1]; vpp = 0; a9 = 0;
      #3;
      chk("R1 drive qualifier", doe, (k == 0));
      if (k != 0) chk("R1 undriven invalid", {dvalid, dout}, 9'h000);
    end
    // R3/R4/R11: two program passes over every address
    for (int i = 0; i < DEPTH; i++) begin
      prog(AW'(i), 8'(i * 37 + 11));
      do_read(AW'(i), "R11 read after program", model[i]);
    end
    for (int i = 0; i < DEPTH; i++) begin
      prog(AW'(i), 8'(i) ^ 8'h5A);
      do_read(AW'(i), "R4 AND on reprogram", model[i]);
    end
    // R3: output enable low with supply flag: no start
    @(negedge clk);
    ce_n = 0; oe_n = 0; vpp = 1; a9 = 0; addr = 8'd3; din = 8'h00;
    pulse("R3 inhibit", 0, 1'b0);
    do_read(8'd3, "R3 inhibit no change", model[3]);
    // R2: chip disabled, both flags, strobe ignored
    @(negedge clk);
    ce_n = 1; oe_n = 1; vpp = 1; a9 = 1; addr = 8'd4; din = 8'h00;
    pulse("R2 standby", 0, 1'b0);
    do_read(8'd4, "R2 standby no change", model[4]);
    do_read(8'd200, "R2 standby no erase", model[200]);
    // R7: identification sweep
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      ce_n = 0; oe_n = 0; vpp = 0; a9 = 1; addr = AW'(i);
      #3;
      chk("R7 id code", {dvalid, dout}, {1'b1, (i % 2 == 1) ? 8'hA5 : 8'hBF});
    end
    // R5/R9: erase with junk address/data, strobe toggled while busy
    @(negedge clk);
    ce_n = 0; oe_n = 1; vpp = 1; a9 = 1; addr = 8'h77; din = 8'h00;
    pulse("R5 erase", ECYC, 1'b1);
    for (int i = 0; i < DEPTH; i++) begin
      model[i] = 8'hFF;
      do_read(AW'(i), "R5 erased content", 8'hFF);
    end
    // R9: strobe edges during a program do not extend or restart it
    @(negedge clk);
    ce_n = 0; oe_n = 1; vpp = 1; a9 = 0; addr = 8'd9; din = 8'h0F;
    pulse("R9 program poked", PCYC, 1'b1);
    do_read(8'd9, "R9 single commit", 8'h0F);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule